// File: doc/BRIEF.md
# Buffered 16-bit Compare Timer/Counter

The block is a 16-bit up-counter with a double-buffered compare value. Software reaches it through a byte-wide register bus at three addresses: compare low byte, compare high byte, and control. When the counter equals the active compare value on a count enable, the counter returns to zero on that same enable and a one-cycle interrupt pulse follows.

The count source is one of several inputs. Four prescaler taps arrive as enable strobes. There is also a low-frequency strobe, the undivided clock, and rising edges on an external pin. In window mode the pin does not count. It gates the internal source instead, so counting advances only while the pin is high.

A new compare value takes effect only after a low-byte write followed by a high-byte write. Until that pair is complete, match detection keeps the old value. A low-power stop request forces the timer off.

Top module: `cmp_timer16`

## Requirements
- R1: Address 0 stages a compare low byte and address 1 supplies the high byte. The 16-bit active compare value changes only on a high-byte write that follows a low-byte write. A lone high-byte write, or a low-byte write with no high byte after it, leaves the active value unchanged.
- R2: Match detection uses the previously active compare value until the high-byte write that completes the sequence.
- R3: Control bit 0 is the start bit. While it is 0 the counter is held at zero and does not count. While it is 1 the counter advances on each count enable.
- R4: Control bits 4:2 select the count source: 000 to 011 pick tap strobes 0 to 3, 100 the low-frequency strobe, 101 every clock, 110 rising edges on the external pin, and 111 nothing.
- R5: Control bit 1 selects the mode (0 = timer/event, 1 = window). The mode and source fields are written only while the start bit is 0. A control write while running changes only the start bit.
- R6: A stop request clears the start bit. The timer stays stopped until software sets the start bit again.
- R7: A compare value of 0 or 1 never produces a match or an interrupt.
- R8: With compare value N ≥ 2, a match occurs on the enable that finds the counter at N. The counter becomes 0 on that enable, and the interrupt is high for exactly one cycle, so matches are N+1 enables apart.
- R9: The external pin passes through two synchroniser flops. In event mode each rising edge gives exactly one count enable.
- R10: In window mode the selected internal source counts only while the synchronised pin is high.
- R11: Reading address 2 returns {3'b000, source, mode, start}. Addresses 0 and 1 return the active compare bytes, and address 3 returns 0. Reset clears the control register and keeps the compare value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| tap_en | input | 4 | Prescaler tap enable strobes |
| slow_en | input | 1 | Low-frequency clock enable strobe |
| ext_pin | input | 1 | Asynchronous external count/gate pin |
| stop_req | input | 1 | Low-power entry request, clears start |
| irq | output | 1 | One-cycle match interrupt pulse |

## Verification
The bench first targets the byte ordering of the compare load. A design that committed on a lone high-byte write, or that applied the low byte at once, would show a different read-back value or a wrong interrupt period. Compare values of 0 and 1 are run with a free-running source, where a design lacking the legality check would fire an interrupt every cycle or two.

Control writes made while running try to change the source. A design that let the change through would read back the new code. Window mode is run with the pin low and then high; if the gate were ignored, interrupts would arrive while the pin is still low.

// File: rtl/cmp_timer16_pkg.sv
package cmp_timer16_pkg;
    localparam int DATA_W = 8;
    localparam int CNT_W  = 2 * DATA_W;
    localparam int N_TAPS = 4;
    localparam int SEL_W  = 3;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] A_CMP_LO = 2'd0;
    localparam logic [ADDR_W-1:0] A_CMP_HI = 2'd1;
    localparam logic [ADDR_W-1:0] A_CTRL   = 2'd2;

    localparam logic [SEL_W-1:0] SRC_SLOW = 3'd4;
    localparam logic [SEL_W-1:0] SRC_FAST = 3'd5;
    localparam logic [SEL_W-1:0] SRC_PIN  = 3'd6;
endpackage

// File: rtl/cmp_timer16_pinsync.sv
module cmp_timer16_pinsync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic lvl,
    output logic rise
);
    typedef struct packed {
        logic [STAGES-1:0] sync;
        logic              prev;
    } st_t;

    st_t d, q;

    always_comb begin
        d      = q;
        d.sync = {q.sync[STAGES-2:0], pin};
        d.prev = q.sync[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign lvl  = q.sync[STAGES-1];
    assign rise = q.sync[STAGES-1] & ~q.prev;
endmodule

// File: rtl/cmp_timer16_srcsel.sv
module cmp_timer16_srcsel
    import cmp_timer16_pkg::*;
#(
    parameter int TAPS = N_TAPS,
    parameter int SW   = SEL_W
) (
    input  logic [SW-1:0]   sel,
    input  logic            window,
    input  logic [TAPS-1:0] tap_en,
    input  logic            slow_en,
    input  logic            pin_lvl,
    input  logic            pin_rise,
    output logic            cnt_en
);
    logic internal_en;

    always_comb begin
        internal_en = 1'b0;
        for (int i = 0; i < TAPS; i++) begin
            if (sel == SW'(i)) internal_en = tap_en[i];
        end
        if (sel == SRC_SLOW) internal_en = slow_en;
        if (sel == SRC_FAST) internal_en = 1'b1;
        if (window)
            cnt_en = internal_en & pin_lvl;
        else if (sel == SRC_PIN)
            cnt_en = pin_rise;
        else
            cnt_en = internal_en;
    end
endmodule

// File: rtl/cmp_timer16_cmpbuf.sv
module cmp_timer16_cmpbuf #(
    parameter int BW = 8,
    parameter int CW = 2 * BW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_lo,
    input  logic          wr_hi,
    input  logic [BW-1:0] wdata,
    output logic [CW-1:0] active
);
    logic          armed_d, armed_q;
    logic [BW-1:0] stage_d, stage_q;
    logic [CW-1:0] act_d, act_q;

    always_comb begin
        armed_d = armed_q;
        stage_d = stage_q;
        act_d   = act_q;
        if (wr_lo) begin
            stage_d = wdata;
            armed_d = 1'b1;
        end else if (wr_hi && armed_q) begin
            act_d   = {wdata, stage_q};
            armed_d = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= armed_d;
    end

    always_ff @(posedge clk) begin
        stage_q <= stage_d;
        act_q   <= act_d;
    end

    assign active = act_q;
endmodule

// File: rtl/cmp_timer16.sv
module cmp_timer16
    import cmp_timer16_pkg::*;
#(
    parameter int BW     = DATA_W,
    parameter int CW     = CNT_W,
    parameter int TAPS   = N_TAPS,
    parameter int SW     = SEL_W,
    parameter int AW     = ADDR_W,
    parameter int STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_wr,
    input  logic [AW-1:0]   bus_addr,
    input  logic [BW-1:0]   bus_wdata,
    output logic [BW-1:0]   bus_rdata,
    input  logic [TAPS-1:0] tap_en,
    input  logic            slow_en,
    input  logic            ext_pin,
    input  logic            stop_req,
    output logic            irq
);
    localparam int MIN_CMP = 2;
    localparam int PAD_W   = BW - SW - 2;

    typedef struct packed {
        logic          start;
        logic          mode;
        logic [SW-1:0] sel;
        logic [CW-1:0] cnt;
        logic          irq;
    } st_t;

    st_t d, q;

    logic          pin_lvl, pin_rise, cnt_en;
    logic [CW-1:0] cmp_act;
    logic          wr_ctrl, cmp_legal;

    cmp_timer16_pinsync #(.STAGES(STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin(ext_pin), .lvl(pin_lvl), .rise(pin_rise)
    );

    cmp_timer16_srcsel #(.TAPS(TAPS), .SW(SW)) u_src (
        .sel(q.sel), .window(q.mode), .tap_en(tap_en), .slow_en(slow_en),
        .pin_lvl(pin_lvl), .pin_rise(pin_rise), .cnt_en(cnt_en)
    );

    cmp_timer16_cmpbuf #(.BW(BW), .CW(CW)) u_cmp (
        .clk(clk), .rst_n(rst_n),
        .wr_lo(bus_wr && bus_addr == A_CMP_LO),
        .wr_hi(bus_wr && bus_addr == A_CMP_HI),
        .wdata(bus_wdata), .active(cmp_act)
    );

    assign wr_ctrl   = bus_wr && bus_addr == A_CTRL;
    assign cmp_legal = cmp_act >= CW'(MIN_CMP);

    always_comb begin
        d     = q;
        d.irq = 1'b0;
        if (wr_ctrl) begin
            d.start = bus_wdata[0];
            if (!q.start) begin
                d.mode = bus_wdata[1];
                d.sel  = bus_wdata[SW+1:2];
            end
        end
        if (stop_req) d.start = 1'b0;

        if (!q.start) begin
            d.cnt = '0;
        end else if (cnt_en) begin
            if (cmp_legal && q.cnt == cmp_act) begin
                d.cnt = '0;
                d.irq = 1'b1;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        case (bus_addr)
            A_CMP_LO: bus_rdata = cmp_act[BW-1:0];
            A_CMP_HI: bus_rdata = cmp_act[CW-1:BW];
            A_CTRL:   bus_rdata = {{PAD_W{1'b0}}, q.sel, q.mode, q.start};
            default:  bus_rdata = '0;
        endcase
    end

    assign irq = q.irq;

    logic          start_q, mode_q;
    logic [SW-1:0] sel_q;
    logic [CW-1:0] cnt_q;
    assign start_q = q.start;
    assign mode_q  = q.mode;
    assign sel_q   = q.sel;
    assign cnt_q   = q.cnt;
endmodule

// File: rtl/cmp_timer16_chk.sv
module cmp_timer16_chk #(
    parameter int CW = 16,
    parameter int SW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          irq,
    input logic          stop_req,
    input logic          start_q,
    input logic          mode_q,
    input logic [SW-1:0] sel_q,
    input logic [CW-1:0] cnt_q,
    input logic [CW-1:0] cmp_act
);
    p_irq_one_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
    p_irq_wraps_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> cnt_q == '0);
    p_irq_needs_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(start_q));
    p_idle_holds_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !start_q |=> cnt_q == '0);
    p_stop_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        stop_req |=> !start_q);
    p_cfg_locked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        start_q |=> ($stable(sel_q) && $stable(mode_q)));
    p_illegal_no_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(cmp_act) >= CW'(2));
endmodule

bind cmp_timer16 cmp_timer16_chk #(.CW(CW), .SW(SW)) u_chk (
    .clk(clk), .rst_n(rst_n), .irq(irq), .stop_req(stop_req),
    .start_q(start_q), .mode_q(mode_q), .sel_q(sel_q),
    .cnt_q(cnt_q), .cmp_act(cmp_act)
);

// File: tb/cmp_timer16_bench.sv
module cmp_timer16_bench;
    localparam int CLK_PERIOD = 10;
    localparam int LIMIT      = 40;
    localparam int NVEC       = 9;
    // {cmp[31:16], sel[15:13], taps[12:9], slow[8], expected cycles to irq [7:0]} (0 = none)
    localparam logic [31:0] VEC [NVEC] = '{
        {16'd5, 3'd0, 4'b0001, 1'b0, 8'd6},
        {16'd5, 3'd1, 4'b0001, 1'b0, 8'd0},
        {16'd7, 3'd3, 4'b1000, 1'b0, 8'd8},
        {16'd6, 3'd2, 4'b0100, 1'b0, 8'd7},
        {16'd3, 3'd4, 4'b0000, 1'b1, 8'd4},
        {16'd9, 3'd5, 4'b0000, 1'b0, 8'd10},
        {16'd4, 3'd7, 4'b1111, 1'b1, 8'd0},
        {16'd1, 3'd5, 4'b0000, 1'b0, 8'd0},
        {16'd0, 3'd5, 4'b0000, 1'b0, 8'd0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [3:0] tap_en = '0;
    logic       slow_en = 1'b0;
    logic       ext_pin = 1'b0;
    logic       stop_req = 1'b0;
    logic       irq;

    int n_chk = 0;
    int n_bad = 0;
    int irq_cnt = 0;
    int n;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmp_timer16 u_cmp_timer16 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tap_en(tap_en),
        .slow_en(slow_en), .ext_pin(ext_pin), .stop_req(stop_req), .irq(irq)
    );

    always @(negedge clk) if (irq) irq_cnt++;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] v);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic measure(output int cyc);
        cyc = 0;
        for (int i = 1; i <= LIMIT; i++) begin
            @(negedge clk);
            if (irq) begin cyc = i; return; end
        end
    endtask

    task automatic load_cmp(input logic [15:0] v);
        wr(2'd0, v[7:0]);
        wr(2'd1, v[15:8]);
    endtask

    task automatic pin_pulse();
        ext_pin = 1'b1; repeat (3) @(negedge clk);
        ext_pin = 1'b0; repeat (3) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int v;
        repeat (3) @(negedge clk);
        rd(2'd2, v); chk("R11 reset ctrl", v, 0);
        chk("R11 reset irq", int'(irq), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: R4 source codes, R7 illegal values, R8 period
        for (int k = 0; k < NVEC; k++) begin
            wr(2'd2, 8'h00);
            load_cmp(VEC[k][31:16]);
            tap_en = VEC[k][12:9]; slow_en = VEC[k][8];
            wr(2'd2, {3'b000, VEC[k][15:13], 1'b0, 1'b1});
            measure(n);
            chk($sformatf("R4/R7/R8 vector %0d", k), n, int'(VEC[k][7:0]));
        end
        tap_en = '0; slow_en = 1'b0;

        // R1: lone high write, lone low write
        wr(2'd2, 8'h00);
        load_cmp(16'h0005);
        wr(2'd1, 8'h12);
        rd(2'd1, v); chk("R1 lone high ignored", v, 0);
        wr(2'd0, 8'h34);
        rd(2'd0, v); chk("R1 lone low not active", v, 5);
        // R2: match still uses 5 while low byte is staged
        wr(2'd2, 8'h15);
        measure(n); chk("R2 old compare in use", n, 6);
        wr(2'd2, 8'h00);
        wr(2'd1, 8'h00);
        rd(2'd0, v); chk("R1 commit low byte", v, 8'h34);
        load_cmp(16'd9);
        wr(2'd2, 8'h15);
        measure(n); chk("R2 new compare after high", n, 10);

        // R5: source change ignored while running
        wr(2'd2, 8'h1F);
        rd(2'd2, v); chk("R5 cfg locked while running", v, 8'h15);
        // R3: stop clears the count
        wr(2'd2, 8'h00);
        load_cmp(16'd10);
        wr(2'd2, 8'h15);
        repeat (4) @(negedge clk);
        wr(2'd2, 8'h14);
        wr(2'd2, 8'h15);
        measure(n); chk("R3 restart from zero", n, 11);

        // R6: stop request
        stop_req = 1'b1; @(negedge clk); stop_req = 1'b0;
        rd(2'd2, v); chk("R6 start cleared", v, 8'h14);
        v = irq_cnt; repeat (30) @(negedge clk);
        chk("R6 no irq after stop", irq_cnt - v, 0);

        // R10: window mode gating
        load_cmp(16'd2);
        ext_pin = 1'b0;
        wr(2'd2, 8'h17);
        v = irq_cnt; repeat (20) @(negedge clk);
        chk("R10 pin low blocks count", irq_cnt - v, 0);
        ext_pin = 1'b1;
        measure(n); chk("R10 pin high counts", n, 5);
        ext_pin = 1'b0;

        // R9: external pin edges in event mode
        wr(2'd2, 8'h00);
        load_cmp(16'd3);
        wr(2'd2, 8'h19);
        v = irq_cnt;
        repeat (3) pin_pulse();
        chk("R9 three edges no irq", irq_cnt - v, 0);
        pin_pulse();
        chk("R9 fourth edge irq", irq_cnt - v, 1);

        // R11: reset keeps compare, clears control
        rst_n = 1'b0; repeat (2) @(negedge clk);
        rd(2'd2, v); chk("R11 ctrl cleared by reset", v, 0);
        rd(2'd0, v); chk("R11 compare kept", v, 3);
        rd(2'd3, v); chk("R11 unused address", v, 0);
        rst_n = 1'b1; @(negedge clk);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule